// File: doc/BRIEF.md
# Power-Bus Command Channel

This block is one command channel of a power-management serial bus master. A host reaches it through a plain 32-bit register port. The host loads up to two write-data words, then writes one command word. That single write starts a transfer. The command word carries the opcode, the slave ID, the register address and the byte count.

The channel passes the transfer to an abstract bus engine over a valid/ready request. It then waits for a response from the engine. The response carries a completion code and up to eight read bytes. The outcome goes into a status register as a done flag plus three error qualifiers. Read bytes go into two read-data words. Serial framing, bus arbitration and wire timing all belong to the engine.

Each channel answers in a 128-byte window at byte address 0x800 + 0x80 × `CHAN_IDX`. Within that window the registers sit at these byte offsets:

- command at 0x00 (reads zero)
- config at 0x04 (reserved, reads zero)
- status at 0x08
- write-data words at 0x10 and 0x14
- read-data words at 0x18 and 0x1C

Top module: `pbus_cmd_channel`

## Requirements
- R1: After reset, status reads 0x0, both read-data words read zero, and no request is presented to the engine.
- R2: A command word is decoded as follows. Bits 31:27 are the opcode and bits 23:20 are the slave ID. Bits 19:4 are the register address and bits 2:0 are the byte count minus one. These values appear on `eng_opcode`, `eng_sid`, `eng_addr` and `eng_bcnt`.
- R3: A command write to an idle channel presents exactly one request. From the next cycle until completion, status reads 0x0.
- R4: While `eng_req_ready` is low, the request stays asserted and every request field stays unchanged.
- R5: `eng_wdata` byte k is taken from write-data word k/4, byte lane k mod 4 (least significant lane first). Bytes above the byte count are zero, so the upper word is all zero when the count field is 3 or less. The data is captured when the command is accepted.
- R6: Status bit 0 (done) is set in the cycle after the response handshake. Bit 1 means failure, bit 2 means denied and bit 3 means dropped. Engine codes map to status as follows:
  - code 0 gives 0x1
  - code 1 gives 0x3
  - code 2 gives 0x5
  - code 3 gives 0x9
- R7: Read opcodes are 1, 8, 13 and 15. When one of them completes with code 0, the response bytes are captured little-endian into the read-data words. Lanes above the byte count read zero. Any other completion leaves both read-data words zero.
- R8: A command write while a transfer is pending is ignored: it issues no request. The pending transfer then completes with the dropped bit (bit 3) set as well.
- R9: Opcodes 3 to 7 carry no data. They present address 0, count 0, `eng_has_data` low and all-zero write data. Opcodes outside that range present `eng_has_data` high.
- R10: Accesses outside the channel's window have no effect and read zero. The write-data words read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from host_addr) |
| eng_req_valid | output | 1 | Request to the engine is valid |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_opcode | output | 5 | Internal opcode |
| eng_sid | output | 4 | Slave ID |
| eng_addr | output | 16 | Slave register address |
| eng_bcnt | output | 3 | Byte count minus one |
| eng_has_data | output | 1 | The transfer has a data phase |
| eng_wdata | output | 64 | Write bytes, little-endian |
| eng_rsp_valid | input | 1 | Engine response is valid |
| eng_rsp_ready | output | 1 | Channel is waiting for a response |
| eng_rsp_code | input | 2 | 0 ok, 1 failure, 2 denied, 3 dropped |
| eng_rsp_rdata | input | 64 | Read bytes, little-endian |

## Verification
The assertions assume the engine raises `eng_rsp_valid` only while `eng_rsp_ready` is high, and only after it has accepted a request. They also assume the response code and data are valid whenever `eng_rsp_valid` is high. The bench engine model follows these rules exactly. It answers one response pulse per accepted request, after a programmed delay, and it may hold ready low for a programmed number of stall cycles. All host accesses come from a single driver, so host traffic never overlaps itself. That driver writes a colliding command only inside the pending window, which lies between acceptance and response.

// File: rtl/pbus_cmd_pkg.sv
package pbus_cmd_pkg;

   // Completion codes returned by the bus engine
   typedef enum logic [1:0] {
      RSP_OK   = 2'd0,
      RSP_FAIL = 2'd1,
      RSP_DENY = 2'd2,
      RSP_DROP = 2'd3
   } rsp_code_e;

   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_REQ  = 2'd1,
      CH_WAIT = 2'd2
   } chan_state_e;

   // Command word field positions (decoded downstream, so fixed)
   localparam int OPC_LSB = 27;
   localparam int SID_LSB = 20;
   localparam int ADR_LSB = 4;
   localparam int BC_LSB  = 0;

   typedef struct packed {
      logic [4:0]  opcode;
      logic [3:0]  sid;
      logic [15:0] addr;
      logic [2:0]  bcnt;
   } cmd_t;

   function automatic logic op_no_data(input logic [4:0] op);
      return (op >= 5'd3) && (op <= 5'd7);
   endfunction

   function automatic logic op_is_read(input logic [4:0] op);
      return (op == 5'd1) || (op == 5'd8) || (op == 5'd13) || (op == 5'd15);
   endfunction

endpackage

// File: rtl/pbus_lane_mask.sv
module pbus_lane_mask #(
   parameter int NBYTE = 8,
   parameter int BC_W  = 3
) (
   input  logic [NBYTE*8-1:0] din,
   input  logic [BC_W-1:0]    last_byte,
   input  logic               enable,
   output logic [NBYTE*8-1:0] dout
);
   for (genvar i = 0; i < NBYTE; i++) begin : g_lane
      localparam logic [BC_W-1:0] IDX = BC_W'(i);
      assign dout[i*8 +: 8] = (enable && (IDX <= last_byte)) ? din[i*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/pbus_cmd_seq.sv
module pbus_cmd_seq
   import pbus_cmd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      launch,
   input  logic      req_ready,
   input  logic      rsp_valid,
   input  rsp_code_e rsp_code,
   output logic      req_valid,
   output logic      rsp_ready,
   output logic      accept,
   output logic      complete,
   output logic [3:0] status
);
   chan_state_e state_q;
   logic        coll_q;

   assign req_valid = (state_q == CH_REQ);
   assign rsp_ready = (state_q == CH_WAIT);
   assign accept    = launch && (state_q == CH_IDLE);
   assign complete  = rsp_ready && rsp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CH_IDLE;
         coll_q  <= 1'b0;
         status  <= 4'h0;
      end else begin
         case (state_q)
            CH_IDLE: if (launch) begin
               state_q <= CH_REQ;
               status  <= 4'h0;
               coll_q  <= 1'b0;
            end
            CH_REQ: begin
               if (launch)    coll_q  <= 1'b1;
               if (req_ready) state_q <= CH_WAIT;
            end
            CH_WAIT: begin
               if (rsp_valid) begin
                  state_q <= CH_IDLE;
                  coll_q  <= 1'b0;
                  status  <= {(rsp_code == RSP_DROP) || coll_q || launch,
                              rsp_code == RSP_DENY,
                              rsp_code == RSP_FAIL,
                              1'b1};
               end else if (launch) begin
                  coll_q <= 1'b1;
               end
            end
            default: state_q <= CH_IDLE;
         endcase
      end
   end

   AST_BUSY_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != CH_IDLE) |-> (status == 4'h0)); // R3
   AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_valid, rsp_ready})); // R3
   AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready) |=> status[0]); // R6
   AST_COLLIDE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_ready && rsp_valid && coll_q) |=> status[3]); // R8
endmodule

// File: rtl/pbus_cmd_channel.sv
module pbus_cmd_channel
   import pbus_cmd_pkg::*;
#(
   parameter int CHAN_IDX = 0,
   parameter int ADDR_W   = 12,
   parameter int WORD_W   = 32,
   parameter int NWORD    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              eng_req_valid,
   input  logic              eng_req_ready,
   output logic [4:0]        eng_opcode,
   output logic [3:0]        eng_sid,
   output logic [15:0]       eng_addr,
   output logic [2:0]        eng_bcnt,
   output logic              eng_has_data,
   output logic [63:0]       eng_wdata,
   input  logic              eng_rsp_valid,
   output logic              eng_rsp_ready,
   input  logic [1:0]        eng_rsp_code,
   input  logic [63:0]       eng_rsp_rdata
);
   localparam int NBYTE   = NWORD * WORD_W / 8;
   localparam int BC_W    = $clog2(NBYTE);
   localparam int WIN_LG  = 7;
   localparam int BASE_I  = 'h800 + CHAN_IDX * (1 << WIN_LG);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_I);
   localparam logic [WIN_LG-1:0] OFF_CMD = 7'h00;
   localparam logic [WIN_LG-1:0] OFF_STA = 7'h08;
   localparam logic [WIN_LG-1:0] OFF_WD0 = 7'h10;
   localparam logic [WIN_LG-1:0] OFF_WD1 = 7'h14;
   localparam logic [WIN_LG-1:0] OFF_RD0 = 7'h18;
   localparam logic [WIN_LG-1:0] OFF_RD1 = 7'h1C;

   if (WORD_W != 32) begin : g_bad_word
      $error("pbus_cmd_channel: WORD_W must be 32");
   end
   if (NWORD != 2) begin : g_bad_nword
      $error("pbus_cmd_channel: NWORD must be 2");
   end
   if (ADDR_W <= WIN_LG || BASE_I + (1 << WIN_LG) > (1 << ADDR_W)) begin : g_bad_addr
      $error("pbus_cmd_channel: channel window does not fit ADDR_W");
   end

   // Host decode
   logic              in_win;
   logic [WIN_LG-1:0] off;
   logic              wr_cmd, wr_wd0, wr_wd1;
   cmd_t              cmd_new;
   logic              unused_cmd_bits;

   assign off     = host_addr[WIN_LG-1:0];
   assign in_win  = (host_addr[ADDR_W-1:WIN_LG] == BASE_V[ADDR_W-1:WIN_LG]);
   assign wr_cmd  = host_wr_en && in_win && (off == OFF_CMD);
   assign wr_wd0  = host_wr_en && in_win && (off == OFF_WD0);
   assign wr_wd1  = host_wr_en && in_win && (off == OFF_WD1);
   assign cmd_new = '{opcode: host_wdata[OPC_LSB +: 5],
                      sid:    host_wdata[SID_LSB +: 4],
                      addr:   host_wdata[ADR_LSB +: 16],
                      bcnt:   host_wdata[BC_LSB +: 3]};
   assign unused_cmd_bits = ^{host_wdata[26:24], host_wdata[3]};

   // Sequencer
   logic       accept, complete;
   logic [3:0] status;

   pbus_cmd_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (wr_cmd),
      .req_ready (eng_req_ready),
      .rsp_valid (eng_rsp_valid),
      .rsp_code  (rsp_code_e'(eng_rsp_code)),
      .req_valid (eng_req_valid),
      .rsp_ready (eng_rsp_ready),
      .accept    (accept),
      .complete  (complete),
      .status    (status)
   );

   // Storage
   logic [WORD_W-1:0] wd_q [NWORD];
   logic [63:0]       wsnap_q;
   logic [63:0]       rd_q;
   cmd_t              cmd_q;
   logic              no_data;
   logic [63:0]       wmasked, rmasked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_q[0] <= '0;
         wd_q[1] <= '0;
         wsnap_q <= '0;
         cmd_q   <= '0;
         rd_q    <= '0;
      end else begin
         if (wr_wd0) wd_q[0] <= host_wdata;
         if (wr_wd1) wd_q[1] <= host_wdata;
         if (accept) begin
            cmd_q   <= cmd_new;
            wsnap_q <= {wd_q[1], wd_q[0]};
         end
         if (complete) rd_q <= rmasked;
      end
   end

   assign no_data = op_no_data(cmd_q.opcode);

   pbus_lane_mask #(.NBYTE(NBYTE), .BC_W(BC_W)) u_wmask (
      .din       (wsnap_q),
      .last_byte (cmd_q.bcnt),
      .enable    (!no_data),
      .dout      (wmasked)
   );

   pbus_lane_mask #(.NBYTE(NBYTE), .BC_W(BC_W)) u_rmask (
      .din       (eng_rsp_rdata),
      .last_byte (cmd_q.bcnt),
      .enable    (op_is_read(cmd_q.opcode) && (eng_rsp_code == RSP_OK)),
      .dout      (rmasked)
   );

   assign eng_opcode   = cmd_q.opcode;
   assign eng_sid      = cmd_q.sid;
   assign eng_addr     = no_data ? 16'h0 : cmd_q.addr;
   assign eng_bcnt     = no_data ? 3'd0 : cmd_q.bcnt;
   assign eng_has_data = !no_data;
   assign eng_wdata    = wmasked;

   // Host read mux
   always_comb begin
      host_rdata = '0;
      if (in_win) begin
         case (off)
            OFF_STA: host_rdata = {28'h0, status};
            OFF_WD0: host_rdata = wd_q[0];
            OFF_WD1: host_rdata = wd_q[1];
            OFF_RD0: host_rdata = rd_q[31:0];
            OFF_RD1: host_rdata = rd_q[63:32];
            default: host_rdata = '0;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req_valid && !eng_req_ready) |=> (eng_req_valid && $stable(eng_opcode)
         && $stable(eng_addr) && $stable(eng_bcnt) && $stable(eng_wdata))); // R4
   AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req_valid && (eng_bcnt < 3'd4)) |-> (eng_wdata[63:32] == 32'h0)); // R5
   AST_NODATA_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req_valid && !eng_has_data) |-> (eng_wdata == 64'h0 && eng_addr == 16'h0)); // R9
endmodule

// File: tb/pbus_cmd_channel_bench.sv
module pbus_cmd_channel_bench;
   localparam int ADDR_W = 12;

   typedef struct packed {
      logic [4:0]  op;
      logic [3:0]  sid;
      logic [15:0] addr;
      logic [2:0]  bc;
      logic        has;
      logic [63:0] wd;
   } exp_req_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_wr_en = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [31:0]       host_wdata = '0;
   logic [31:0]       host_rdata;
   logic              eng_req_valid, eng_req_ready, eng_has_data;
   logic [4:0]        eng_opcode;
   logic [3:0]        eng_sid;
   logic [15:0]       eng_addr;
   logic [2:0]        eng_bcnt;
   logic [63:0]       eng_wdata;
   logic              eng_rsp_valid, eng_rsp_ready;
   logic [1:0]        eng_rsp_code;
   logic [63:0]       eng_rsp_rdata;

   int total = 0;
   int bad   = 0;

   exp_req_t    exp_q[$];
   int          stall_left = 0;
   int          rsp_delay  = 2;
   logic [1:0]  plan_code  = 2'd0;
   logic [63:0] plan_rdata = '0;

   always #4 clk = ~clk;

   pbus_cmd_channel u_pbus_cmd_channel (
      .clk, .rst_n, .host_wr_en, .host_addr, .host_wdata, .host_rdata,
      .eng_req_valid, .eng_req_ready, .eng_opcode, .eng_sid, .eng_addr,
      .eng_bcnt, .eng_has_data, .eng_wdata, .eng_rsp_valid, .eng_rsp_ready,
      .eng_rsp_code, .eng_rsp_rdata
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] lanes(input logic [63:0] d, input int bc);
      logic [63:0] r = '0;
      for (int k = 0; k < 8; k++) if (k <= bc) r[k*8 +: 8] = d[k*8 +: 8];
      return r;
   endfunction

   function automatic exp_req_t mk_exp(input logic [4:0] op, input logic [3:0] sid,
      input logic [15:0] addr, input logic [2:0] bc, input logic [63:0] wd);
      exp_req_t e;
      logic nd = (op >= 5'd3 && op <= 5'd7);
      e.op = op; e.sid = sid;
      e.addr = nd ? 16'h0 : addr;
      e.bc   = nd ? 3'd0 : bc;
      e.has  = !nd;
      e.wd   = nd ? 64'h0 : lanes(wd, int'(bc));
      return e;
   endfunction

   // Engine model and request monitor (R2, R4, R5, R9)
   initial begin
      eng_req_ready = 1'b0;
      eng_rsp_valid = 1'b0;
      eng_rsp_code  = 2'd0;
      eng_rsp_rdata = '0;
      forever begin
         @(negedge clk);
         if (eng_req_valid) begin
            exp_req_t got;
            got = '{eng_opcode, eng_sid, eng_addr, eng_bcnt, eng_has_data, eng_wdata};
            if (exp_q.size() == 0) begin
               check("R8 unexpected request", 128'(got), 128'(0));
               eng_req_ready = 1'b1;
               @(negedge clk);
               eng_req_ready = 1'b0;
            end else if (stall_left > 0) begin
               stall_left--;
               eng_req_ready = 1'b0;
               check("R4 request held during stall", 128'(got), 128'(exp_q[0]));
            end else begin
               check("R2/R5/R9 request fields", 128'(got), 128'(exp_q.pop_front()));
               eng_req_ready = 1'b1;
               @(negedge clk);
               eng_req_ready = 1'b0;
               repeat (rsp_delay) @(negedge clk);
               eng_rsp_code  = plan_code;
               eng_rsp_rdata = plan_rdata;
               eng_rsp_valid = 1'b1;
               @(negedge clk);
               eng_rsp_valid = 1'b0;
            end
         end
      end
   end

   task automatic host_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr_en = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr_en = 1'b0;
   endtask

   task automatic host_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic run_cmd(input string req, input logic [4:0] op, input logic [3:0] sid,
      input logic [15:0] addr, input logic [2:0] bc, input logic [31:0] w0, input logic [31:0] w1,
      input logic [1:0] code, input logic [63:0] rdat, input int stall, input bit collide,
      input logic [3:0] exp_sta, input logic [63:0] exp_rd);
      logic [31:0] v;
      host_write(12'h810, w0);
      host_write(12'h814, w1);
      plan_code = code; plan_rdata = rdat; stall_left = stall;
      exp_q.push_back(mk_exp(op, sid, addr, bc, {w1, w0}));
      host_write(12'h800, {op, 3'b000, sid, addr, 1'b0, bc});
      host_read(12'h808, v);
      check("R3 status clear while pending", 128'(v), 128'(0));
      if (collide) host_write(12'h800, {5'd14, 3'b000, 4'h1, 16'h0001, 1'b0, 3'd0});
      for (int i = 0; i < 60; i++) begin
         host_read(12'h808, v);
         if (v[0]) break;
      end
      check({req, " status"}, 128'(v), 128'(exp_sta));
      host_read(12'h818, v);
      check({req, " rdata0"}, 128'(v), 128'(exp_rd[31:0]));
      host_read(12'h81C, v);
      check({req, " rdata1"}, 128'(v), 128'(exp_rd[63:32]));
      check({req, " request consumed"}, 128'(exp_q.size()), 128'(0));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : driver
      logic [31:0] v;
      repeat (3) @(negedge clk);
      check("R1 no request in reset", 128'(eng_req_valid), 128'(0));
      rst_n = 1'b1;
      host_read(12'h808, v); check("R1 status after reset", 128'(v), 128'(0));
      host_read(12'h818, v); check("R1 rdata0 after reset", 128'(v), 128'(0));
      host_read(12'h81C, v); check("R1 rdata1 after reset", 128'(v), 128'(0));
      check("R1 request idle", 128'(eng_req_valid), 128'(0));

      // R10 window decode
      host_write(12'h890, 32'hDEADBEEF);
      host_read(12'h810, v); check("R10 other window ignored", 128'(v), 128'(0));
      host_read(12'h890, v); check("R10 outside reads zero", 128'(v), 128'(0));
      host_write(12'h814, 32'hA5A5_0F0F);
      host_read(12'h814, v); check("R10 write data readback", 128'(v), 128'(32'hA5A5_0F0F));
      host_write(12'h880, {5'd14, 27'h0});
      repeat (3) @(negedge clk);
      check("R10 foreign command no request", 128'(eng_req_valid), 128'(0));

      // R2 R5 R6: full write, ok
      run_cmd("R6 write ok", 5'd14, 4'h5, 16'h1234, 3'd7, 32'h4433_2211, 32'h8877_6655,
              2'd0, 64'h0, 0, 0, 4'h1, 64'h0);
      // R5 short write, failure
      run_cmd("R6 short write fail", 5'd0, 4'hA, 16'h00C3, 3'd2, 32'hDDCC_BBAA, 32'hFFFF_FFFF,
              2'd1, 64'h0, 0, 0, 4'h3, 64'h0);
      // R7 read with partial lanes
      run_cmd("R7 read partial", 5'd15, 4'hF, 16'hFFFF, 3'd5, 32'h0, 32'h0,
              2'd0, 64'h1122_3344_5566_7788, 0, 0, 4'h1, 64'h0000_3344_5566_7788);
      run_cmd("R7 ext read one byte", 5'd13, 4'h3, 16'h0040, 3'd0, 32'h0, 32'h0,
              2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 4'h1, 64'h0000_0000_0000_00FF);
      // R7 denied read leaves zero
      run_cmd("R7 denied read", 5'd1, 4'h2, 16'h0100, 3'd3, 32'h0, 32'h0,
              2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 4'h5, 64'h0);
      // R9 non-data, dropped code
      run_cmd("R9 sleep dropped", 5'd4, 4'h2, 16'hABCD, 3'd7, 32'h1111_1111, 32'h2222_2222,
              2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 4'h9, 64'h0);
      // R4 stall and R8 collision
      run_cmd("R8 collision", 5'd2, 4'h7, 16'h0055, 3'd4, 32'h0403_0201, 32'h0807_0605,
              2'd0, 64'h0, 4, 1, 4'h9, 64'h0);
      // R3 dropped cleared by next command; master read full
      run_cmd("R3 next after collision", 5'd8, 4'h1, 16'h0200, 3'd7, 32'h0, 32'h0,
              2'd0, 64'hCAFE_F00D_1234_5678, 2, 0, 4'h1, 64'hCAFE_F00D_1234_5678);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule